// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller

This block gathers 128 level-sensitive interrupt requests for one processor. Each request is the OR of a hardware line and a software-forced bit. A per-source mask gates the request. The controller picks one unmasked pending source and raises a single interrupt output. It then keeps that choice until software acknowledges it through a register write.

Software reaches the block over a simple 32-bit register bus with a byte address, a write strobe, a read strobe and registered read data. The sources are split into four banks of 32. Each bank has write-one registers that set or clear mask bits and that set or clear software-forced bits. The active-source register returns the chosen source number. Its upper bits are all ones when no valid source is currently held. The block also has a revision register, a priority threshold register and a soft reset that reports when it has finished.

Top module: `lvl_intc_top`

## Requirements
- R1: After the synchronous reset, all 128 mask bits read 1, all software-forced bits read 0, the threshold reads 0xFF, the status register (0x14) bit 0 reads 1 and `irq_o` is low.
- R2: Offset 0x00 is read-only and reads the major revision in bits 7:4 and the minor revision in bits 3:0 (0x50 by default). Writes to it have no effect.
- R3: For bank b (b = 0..3), a write to 0x88+0x20*b clears each mask bit whose data bit is 1, and a write to 0x8C+0x20*b sets it. Data bits at 0 leave the mask unchanged. Reading either address returns that bank's mask.
- R4: For bank b, a write to 0x90+0x20*b sets software-forced bits and a write to 0x94+0x20*b clears them, using write-one semantics. Reading either address returns that bank's forced bits.
- R5: Source n belongs to bank n[6:5] at bit n[4:0]. It is pending while its line or its forced bit is 1 and its mask bit is 0.
- R6: When nothing is held and sources are pending, the lowest-numbered pending source is latched on the next clock edge and `irq_o` reads 1 after that edge.
- R7: While a source is held, `irq_o` and the held number stay fixed, even if a lower-numbered source becomes pending or the held source stops pending.
- R8: A write to the control register (0x48) with bit 0 set releases the held source, so `irq_o` is low after that edge. Arbitration resumes on the following edge. A write with bit 0 clear has no effect.
- R9: A read of 0x40 returns the held number in bits 6:0. Bits 31:7 are 0 when a source is held and still pending, and all ones otherwise, with the stale number kept in bits 6:0.
- R10: A write to 0x10 with bit 1 set starts a soft reset. Status bit 0 reads 0 until SRST_CYCLES edges after the write, then reads 1. Masks, forced bits, threshold and the held state return to their reset values.
- R11: The threshold register at 0x68 is 8 bits wide and can be read and written. A value of 0 blocks every source from arbitration, and any nonzero value lets all unmasked sources through.
- R12: Read data appears on `rd_data` on the edge where `reg_rd` is sampled high. Addresses that map to no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| irq_lines | input | 128 | Level request lines, bit n is source n |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench makes a lower-numbered source pending while a higher one is held. A design that re-arbitrates without an acknowledge would switch the reported number. It drops the held source before the active read, so a design that fails to flag staleness would return a clean number for a source that no longer needs service. It also writes zero data to the write-one registers and to the control register, and writes to the revision register, so logic that treats those registers as plain stores would corrupt masks or release the interrupt. Threshold 0 and the soft-reset countdown are checked cycle by cycle: a controller that ignores the threshold would interrupt, and one that reports completion at once would show status 1 too early.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;
  localparam int unsigned BANK_W   = 32;
  localparam int unsigned DATA_W   = 32;
  localparam logic [7:0] OFF_REV   = 8'h00;
  localparam logic [7:0] OFF_CFG   = 8'h10;
  localparam logic [7:0] OFF_STAT  = 8'h14;
  localparam logic [7:0] OFF_ACT   = 8'h40;
  localparam logic [7:0] OFF_CTRL  = 8'h48;
  localparam logic [7:0] OFF_THR   = 8'h68;
  localparam logic [7:0] OFF_MCLR  = 8'h88;
  localparam logic [7:0] OFF_MSET  = 8'h8C;
  localparam logic [7:0] OFF_TSET  = 8'h90;
  localparam logic [7:0] OFF_TCLR  = 8'h94;
  localparam logic [7:0] BANK_STEP = 8'h20;
endpackage

// File: rtl/lvl_intc_bank.sv
module lvl_intc_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic         wr_mclr,
  input  logic         wr_mset,
  input  logic         wr_tset,
  input  logic         wr_tclr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] lines,
  output logic [W-1:0] mask,
  output logic [W-1:0] force_q,
  output logic [W-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      mask    <= '1;
      force_q <= '0;
    end else begin
      if (wr_mclr) mask <= mask & ~wdata;
      else if (wr_mset) mask <= mask | wdata;
      if (wr_tset) force_q <= force_q | wdata;
      else if (wr_tclr) force_q <= force_q & ~wdata;
    end
  end

  assign pend = (lines | force_q) & ~mask;
endmodule

// File: rtl/lvl_intc_pick.sv
module lvl_intc_pick #(
  parameter int unsigned N   = 128,
  localparam int unsigned IDW = $clog2(N)
) (
  input  logic [N-1:0]   req,
  output logic           any,
  output logic [IDW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = i[IDW-1:0];
      end
    end
  end
endmodule

// File: rtl/lvl_intc_top.sv
module lvl_intc_top
  import lvl_intc_pkg::*;
#(
  parameter int unsigned NSRC        = 128,
  parameter int unsigned SRST_CYCLES = 4,
  parameter logic [3:0]  REV_MAJOR   = 4'h5,
  parameter logic [3:0]  REV_MINOR   = 4'h0,
  localparam int unsigned NBANK = NSRC / BANK_W,
  localparam int unsigned IDW   = $clog2(NSRC),
  localparam int unsigned CNT_W = $clog2(SRST_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NSRC-1:0]   irq_lines,
  output logic              irq_o
);
  logic [NSRC-1:0] mask_all, force_all, pend_raw, pick_req;
  logic [NBANK-1:0] wr_mclr, wr_mset, wr_tset, wr_tclr;
  logic             ack_wr, srst_wr, clr_all;
  logic [CNT_W-1:0] srst_cnt;
  logic             done_q;
  logic [7:0]       thresh_q;
  logic             busy_q;
  logic [IDW-1:0]   held_id;
  logic             pick_any;
  logic [IDW-1:0]   pick_idx;

  assign ack_wr  = reg_we && (reg_addr == OFF_CTRL) && reg_wdata[0];
  assign srst_wr = reg_we && (reg_addr == OFF_CFG) && reg_wdata[1];
  assign clr_all = srst_wr || (srst_cnt != '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [7:0] BOFS = 8'(b) * BANK_STEP;
    assign wr_mclr[b] = reg_we && (reg_addr == OFF_MCLR + BOFS);
    assign wr_mset[b] = reg_we && (reg_addr == OFF_MSET + BOFS);
    assign wr_tset[b] = reg_we && (reg_addr == OFF_TSET + BOFS);
    assign wr_tclr[b] = reg_we && (reg_addr == OFF_TCLR + BOFS);
    lvl_intc_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .clr_all (clr_all),
      .wr_mclr (wr_mclr[b]),
      .wr_mset (wr_mset[b]),
      .wr_tset (wr_tset[b]),
      .wr_tclr (wr_tclr[b]),
      .wdata   (reg_wdata),
      .lines   (irq_lines[b*BANK_W +: BANK_W]),
      .mask    (mask_all[b*BANK_W +: BANK_W]),
      .force_q (force_all[b*BANK_W +: BANK_W]),
      .pend    (pend_raw[b*BANK_W +: BANK_W])
    );
  end

  assign pick_req = (thresh_q != 8'h00) ? pend_raw : '0;

  lvl_intc_pick #(.N(NSRC)) u_pick (
    .req (pick_req),
    .any (pick_any),
    .idx (pick_idx)
  );

  // soft reset countdown and completion flag
  always_ff @(posedge clk) begin
    if (rst) begin
      srst_cnt <= '0;
      done_q   <= 1'b1;
    end else if (srst_wr) begin
      srst_cnt <= CNT_W'(SRST_CYCLES);
      done_q   <= 1'b0;
    end else if (srst_cnt != '0) begin
      srst_cnt <= srst_cnt - 1'b1;
      if (srst_cnt == CNT_W'(1)) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) thresh_q <= 8'hFF;
    else if (reg_we && reg_addr == OFF_THR) thresh_q <= reg_wdata[7:0];
  end

  // hold the selected source until acknowledged
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      busy_q  <= 1'b0;
      held_id <= '0;
    end else if (busy_q) begin
      if (ack_wr) busy_q <= 1'b0;
    end else if (pick_any) begin
      busy_q  <= 1'b1;
      held_id <= pick_idx;
    end
  end

  assign irq_o = busy_q;

  logic [DATA_W-1:0] rd_next;
  logic              stale;
  assign stale = !busy_q || !pend_raw[held_id];

  always_comb begin
    rd_next = '0;
    if (reg_addr == OFF_REV) rd_next = {24'h0, REV_MAJOR, REV_MINOR};
    else if (reg_addr == OFF_STAT) rd_next = {31'h0, done_q};
    else if (reg_addr == OFF_THR) rd_next = {24'h0, thresh_q};
    else if (reg_addr == OFF_ACT)
      rd_next = {{(DATA_W-IDW){stale}}, held_id};
    for (int b = 0; b < NBANK; b++) begin
      if (reg_addr == OFF_MCLR + 8'(b) * BANK_STEP ||
          reg_addr == OFF_MSET + 8'(b) * BANK_STEP)
        rd_next = mask_all[b*BANK_W +: BANK_W];
      if (reg_addr == OFF_TSET + 8'(b) * BANK_STEP ||
          reg_addr == OFF_TCLR + 8'(b) * BANK_STEP)
        rd_next = force_all[b*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (reg_rd) rd_data <= rd_next;
  end
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk #(
  parameter int unsigned NSRC = 128,
  localparam int unsigned IDW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_o,
  input logic [IDW-1:0]  held_id,
  input logic [NSRC-1:0] pick_req,
  input logic            ack_wr,
  input logic            srst_wr,
  input logic            done_q
);
  logic [NSRC-1:0] req_q;
  localparam logic [NSRC-1:0] ONE = NSRC'(1);
  always_ff @(posedge clk) req_q <= pick_req;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !irq_o); // R1
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (req_q[held_id] && ((req_q & ((ONE << held_id) - ONE)) == '0))); // R6
  AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_wr && !srst_wr) |=> (irq_o && $stable(held_id))); // R7
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_wr) |=> !irq_o); // R8
  AST_SRST_BUSY: assert property (@(posedge clk) disable iff (rst)
    srst_wr |=> (!done_q && !irq_o)); // R10
endmodule

bind lvl_intc_top lvl_intc_chk #(.NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_o    (irq_o),
  .held_id  (held_id),
  .pick_req (pick_req),
  .ack_wr   (ack_wr),
  .srst_wr  (srst_wr),
  .done_q   (done_q)
);

// File: tb/lvl_intc_top_tb_top.sv
module lvl_intc_top_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   reg_addr = '0;
  logic         reg_we = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic         reg_rd = 1'b0;
  logic [31:0]  rd_data;
  logic [127:0] irq_lines = '0;
  logic         irq_o;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lvl_intc_top dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .rd_data(rd_data),
    .irq_lines(irq_lines), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = rd_data;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq_o), 0);
    for (int b = 0; b < 4; b++) begin
      rd(8'h88 + 8'(b) * 8'h20, d); check("R1 mask", d, 32'hFFFFFFFF);
      rd(8'h90 + 8'(b) * 8'h20, d); check("R1 force", d, 0);
    end
    rd(8'h68, d); check("R1 thresh", d, 32'hFF);
    rd(8'h14, d); check("R1 status", d, 1);
    rd(8'h40, d); check("R9 idle active", d, 32'hFFFFFF80);
  endtask

  task automatic t_rev();
    logic [31:0] d;
    rd(8'h00, d); check("R2 rev", d, 32'h50);
    wr(8'h00, 32'hFFFFFFFF);
    rd(8'h00, d); check("R2 rev ro", d, 32'h50);
    rd(8'h04, d); check("R12 unmapped", d, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'hA8, 32'h000000F0);
    rd(8'hA8, d); check("R3 clr", d, 32'hFFFFFF0F);
    wr(8'hAC, 32'h00000010);
    rd(8'hAC, d); check("R3 set", d, 32'hFFFFFF1F);
    wr(8'hA8, 32'h0);
    rd(8'hA8, d); check("R3 zero", d, 32'hFFFFFF1F);
  endtask

  task automatic t_force();
    logic [31:0] d;
    wr(8'hD0, 32'h5);
    wr(8'hD4, 32'h1);
    rd(8'hD0, d); check("R4 set clr", d, 32'h4);
    wr(8'hD4, 32'h0);
    rd(8'hD4, d); check("R4 zero", d, 32'h4);
    tick(2); check("R5 masked force", 32'(irq_o), 0);
    wr(8'hD4, 32'h4);
  endtask

  task automatic t_select();
    logic [31:0] d;
    irq_lines[40] = 1'b1;
    tick(2); check("R5 masked line", 32'(irq_o), 0);
    wr(8'hA8, 32'h100);
    tick(1); check("R6 irq", 32'(irq_o), 1);
    rd(8'h40, d); check("R6 id 40", d, 32'd40);
  endtask

  task automatic t_hold_ack();
    logic [31:0] d;
    irq_lines[3] = 1'b1;
    wr(8'h88, 32'h8);
    tick(2);
    rd(8'h40, d); check("R7 held", d, 32'd40);
    wr(8'h48, 32'h2);
    tick(1); check("R8 ack zero", 32'(irq_o), 1);
    wr(8'h48, 32'h1);
    check("R8 drop", 32'(irq_o), 0);
    tick(1); check("R8 rearb", 32'(irq_o), 1);
    rd(8'h40, d); check("R6 lowest", d, 32'd3);
  endtask

  task automatic t_spurious();
    logic [31:0] d;
    irq_lines[3] = 1'b0;
    tick(1); check("R7 stays", 32'(irq_o), 1);
    rd(8'h40, d); check("R9 stale", d, 32'hFFFFFF83);
    wr(8'h48, 32'h1);
    tick(1);
    rd(8'h40, d); check("R9 next", d, 32'd40);
  endtask

  task automatic t_force_src();
    logic [31:0] d;
    wr(8'hF0, 32'h80000000);
    wr(8'hE8, 32'h80000000);
    irq_lines[40] = 1'b0;
    wr(8'h48, 32'h1);
    tick(1);
    rd(8'h40, d); check("R5 force 127", d, 32'h7F);
    wr(8'hF4, 32'h80000000);
    rd(8'h40, d); check("R9 force gone", d, 32'hFFFFFFFF);
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    wr(8'h48, 32'h1);
    wr(8'h68, 32'h0);
    irq_lines[37] = 1'b1;
    tick(3); check("R11 blocked", 32'(irq_o), 0);
    rd(8'h68, d); check("R11 readback", d, 0);
    rd(8'h40, d); check("R9 idle stale", d, 32'hFFFFFFFF);
    wr(8'h68, 32'h10);
    tick(1); check("R11 open", 32'(irq_o), 1);
    rd(8'h40, d); check("R11 id 37", d, 32'd37);
  endtask

  task automatic t_srst();
    logic [31:0] d;
    wr(8'h10, 32'h2);
    check("R10 irq", 32'(irq_o), 0);
    rd(8'h14, d); check("R10 busy", d, 0);
    tick(6);
    rd(8'h14, d); check("R10 done", d, 1);
    rd(8'hA8, d); check("R10 mask", d, 32'hFFFFFFFF);
    rd(8'h68, d); check("R10 thresh", d, 32'hFF);
    rd(8'h40, d); check("R10 active", d, 32'hFFFFFF80);
    check("R10 quiet", 32'(irq_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rev();
    t_mask();
    t_force();
    t_select();
    t_hold_ack();
    t_spurious();
    t_force_src();
    t_thresh();
    t_srst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule